// File: doc/BRIEF.md
# Half to Double Precision Widening Converter

This block takes a 16-bit half-precision floating-point value and produces the 64-bit double-precision value of equal magnitude and sign. Widening is always exact, so no rounding logic is present. Signed zeros and infinities pass through. Subnormal halves are normalized into ordinary double normals. NaNs come out quiet with their payload kept, and a signalling NaN input raises an invalid flag that travels alongside the result.

A control pin, `alt_mode`, selects an alternative half-precision encoding that has no infinities or NaNs. In that encoding the all-ones exponent is just the largest finite binade. The pin is read together with the data word at the moment the word is accepted.

The converter is one register stage with a valid/ready stream on each side. A word is taken when `in_valid` and `in_ready` are both high. Its result appears on the next cycle with `out_valid` high. While `out_valid` is high and `out_ready` is low, the result and flag hold still and `in_ready` stays low. When the output slot is empty or is being drained in the same cycle, `in_ready` is high, so full throughput is one word per cycle.

Top module: `hcvt_widen`

## Requirements
- R1: A half input with exponent field e (bits 14:10) in 1..30 and fraction f (bits 9:0) yields sign = input bit 15, double exponent (bits 62:52) = e + 1008, and double fraction (bits 51:0) = f shifted left by 42. The invalid flag is 0.
- R2: An input with exponent 0 and fraction 0 yields a double whose bit 63 equals input bit 15 and whose other bits are all zero. The invalid flag is 0.
- R3: An input with exponent 0 and nonzero fraction f has value f·2^-24. Let p be the index of the highest set bit of f. The output exponent is p + 999, and the fraction is f with that bit cleared, shifted left by 52 − p. Sign is kept and the invalid flag is 0.
- R4: With `alt_mode` = 0, exponent 31 and fraction 0 yield a signed infinity: exponent 0x7FF and fraction 0. The invalid flag is 0.
- R5: With `alt_mode` = 0, exponent 31 and nonzero fraction f yield a NaN. The output has the input sign, exponent 0x7FF, and fraction (f << 42) with bit 51 forced to 1.
- R6: With `alt_mode` = 1, exponent 31 is finite: the output has exponent 1039 and fraction f << 42. The invalid flag is 0.
- R7: `out_invalid` is 1 exactly when the accepted word was a NaN under `alt_mode` = 0 with fraction bit 9 clear (signalling). Otherwise it is 0.
- R8: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted word's result is presented on the following cycle with `out_valid` high. While `out_valid` is high and `out_ready` is low, `out_double` and `out_invalid` hold their values.
- R9: While `rst` is high, and on the first cycle after it, `out_valid` is low.
- R10: `alt_mode` is captured with the word at acceptance. Changing it while a result is held does not alter that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alt_mode | input | 1 | 1 selects the encoding with no infinities or NaNs |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Converter can take a word this cycle |
| in_half | input | 16 | Half-precision operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_double | output | 64 | Double-precision result |
| out_invalid | output | 1 | Signalling NaN was converted |

## Verification
All 65,536 half encodings are converted under both modes. Expected results are computed by building the value as a real number, or as explicit bit patterns for the special codes. Several corner cases are targeted. A subnormal normalizer with an off-by-one shift or exponent would misplace every subnormal by a factor of two. A converter that ignored `alt_mode` would turn the top binade into infinities and NaNs. Dropping the quiet-bit force or inverting the signalling test would show up as wrong NaN fractions or a wrong invalid flag. A stall phase holds `out_ready` low while the input word and mode change, which catches a register that reloads while its result is still unconsumed.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } hcvt_cls_e;
endpackage

// File: rtl/hcvt_classify.sv
module hcvt_classify
  import hcvt_pkg::*;
#(
  parameter int EH = 5,
  parameter int FH = 10
) (
  input  logic [EH-1:0] exp_i,
  input  logic [FH-1:0] frac_i,
  input  logic          alt_i,
  output hcvt_cls_e     cls_o
);
  logic exp_zero, exp_top, frac_zero;

  always_comb begin
    exp_zero  = (exp_i == '0);
    exp_top   = (exp_i == '1);
    frac_zero = (frac_i == '0);
    if (exp_zero)
      cls_o = frac_zero ? CLS_ZERO : CLS_SUB;
    else if (exp_top && !alt_i)
      cls_o = frac_zero ? CLS_INF : CLS_NAN;
    else
      cls_o = CLS_NORM;
  end
endmodule

// File: rtl/hcvt_lead.sv
module hcvt_lead #(
  parameter int W  = 10,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  val_i,
  output logic [PW-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) pos_o = PW'(i);
    end
  end
endmodule

// File: rtl/hcvt_assemble.sv
module hcvt_assemble
  import hcvt_pkg::*;
#(
  parameter int EH = 5,
  parameter int FH = 10,
  parameter int ED = 11,
  parameter int FD = 52,
  localparam int PW = (FH > 1) ? $clog2(FH) : 1
) (
  input  hcvt_cls_e        cls_i,
  input  logic             sign_i,
  input  logic [EH-1:0]    exp_i,
  input  logic [FH-1:0]    frac_i,
  input  logic [PW-1:0]    lead_i,
  output logic [ED+FD:0]   dbl_o,
  output logic             inv_o
);
  localparam int BIAS_H   = (1 << (EH - 1)) - 1;
  localparam int BIAS_D   = (1 << (ED - 1)) - 1;
  localparam int NORM_ADJ = BIAS_D - BIAS_H;
  localparam int SUB_ADJ  = BIAS_D + 1 - BIAS_H - FH;
  localparam int PAD      = FD - FH;

  logic [ED-1:0] exp_d;
  logic [FH-1:0] frac_d;
  logic [FH-1:0] sub_frac;
  logic [PW:0]   sub_shift;

  always_comb begin
    sub_shift = (PW+1)'(FH) - {1'b0, lead_i};
    sub_frac  = frac_i << sub_shift;
    inv_o     = 1'b0;
    exp_d     = '0;
    frac_d    = '0;
    unique case (cls_i)
      CLS_ZERO: begin
        exp_d  = '0;
        frac_d = '0;
      end
      CLS_SUB: begin
        exp_d  = ED'(lead_i) + ED'(SUB_ADJ);
        frac_d = sub_frac;
      end
      CLS_NORM: begin
        exp_d  = ED'(exp_i) + ED'(NORM_ADJ);
        frac_d = frac_i;
      end
      CLS_INF: begin
        exp_d  = '1;
        frac_d = '0;
      end
      CLS_NAN: begin
        exp_d  = '1;
        frac_d = frac_i | {1'b1, {(FH-1){1'b0}}};
        inv_o  = ~frac_i[FH-1];
      end
      default: begin
        exp_d  = '0;
        frac_d = '0;
      end
    endcase
    dbl_o = {sign_i, exp_d, frac_d, {PAD{1'b0}}};
  end
endmodule

// File: rtl/hcvt_widen.sv
module hcvt_widen
  import hcvt_pkg::*;
#(
  parameter int EH = 5,
  parameter int FH = 10,
  parameter int ED = 11,
  parameter int FD = 52
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alt_mode,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [EH+FH:0]  in_half,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ED+FD:0]  out_double,
  output logic            out_invalid
);
  localparam int PW = (FH > 1) ? $clog2(FH) : 1;

  logic          h_sign;
  logic [EH-1:0] h_exp;
  logic [FH-1:0] h_frac;
  hcvt_cls_e     cls;
  logic [PW-1:0] lead;
  logic [ED+FD:0] dbl_next;
  logic          inv_next;
  logic          take;

  assign h_sign = in_half[EH+FH];
  assign h_exp  = in_half[EH+FH-1:FH];
  assign h_frac = in_half[FH-1:0];

  hcvt_classify #(.EH(EH), .FH(FH)) u_cls (
    .exp_i  (h_exp),
    .frac_i (h_frac),
    .alt_i  (alt_mode),
    .cls_o  (cls)
  );

  hcvt_lead #(.W(FH)) u_lead (
    .val_i (h_frac),
    .pos_o (lead)
  );

  hcvt_assemble #(.EH(EH), .FH(FH), .ED(ED), .FD(FD)) u_asm (
    .cls_i  (cls),
    .sign_i (h_sign),
    .exp_i  (h_exp),
    .frac_i (h_frac),
    .lead_i (lead),
    .dbl_o  (dbl_next),
    .inv_o  (inv_next)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_double  <= '0;
      out_invalid <= 1'b0;
    end else if (take) begin
      out_double  <= dbl_next;
      out_invalid <= inv_next;
    end
  end
endmodule

// File: rtl/hcvt_widen_chk.sv
module hcvt_widen_chk #(
  parameter int EH = 5,
  parameter int FH = 10,
  parameter int ED = 11,
  parameter int FD = 52
) (
  input logic            clk,
  input logic            rst,
  input logic            alt_mode,
  input logic            in_valid,
  input logic            in_ready,
  input logic [EH+FH:0]  in_half,
  input logic            out_valid,
  input logic            out_ready,
  input logic [ED+FD:0]  out_double,
  input logic            out_invalid
);
  // R8: an unconsumed result holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_double) && $stable(out_invalid));

  // R8: an accepted word shows up one cycle later
  a_r8_fire: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R2: sign of the result follows the accepted word
  a_r2_sign: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_double[ED+FD] == $past(in_half[EH+FH]));

  // R7: a raised flag only comes with a quiet NaN result
  a_r7_inv_nan: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_invalid |-> (out_double[ED+FD-1:FD] == '1) && out_double[FD-1]);

  // R4: an infinity result never raises the flag
  a_r4_inf_clean: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_double[ED+FD-1:FD] == '1) && (out_double[FD-1:0] == '0) |-> !out_invalid);

  // R6: the alternative encoding never produces the all-ones double exponent
  a_r6_alt_finite: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && alt_mode |=> out_double[ED+FD-1:FD] != '1);
endmodule

bind hcvt_widen hcvt_widen_chk #(.EH(EH), .FH(FH), .ED(ED), .FD(FD)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .alt_mode    (alt_mode),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_half     (in_half),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_double  (out_double),
  .out_invalid (out_invalid)
);

// File: tb/sim_hcvt_widen.sv
module sim_hcvt_widen;
  logic        clk = 1'b0;
  logic        rst;
  logic        alt_mode;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_half;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_double;
  logic        out_invalid;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  hcvt_widen u0 (
    .clk(clk), .rst(rst), .alt_mode(alt_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_half(in_half),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_double(out_double), .out_invalid(out_invalid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic real pow2(int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else        for (int i = 0; i < -n; i++) r = r * 0.5;
    return r;
  endfunction

  // returns {invalid, double}; tag names the requirement
  function automatic logic [64:0] model(logic [15:0] h, logic alt, output string tag);
    logic s; int e; int f; real v;
    s = h[15]; e = int'(h[14:10]); f = int'(h[9:0]);
    if (e == 0 && f == 0) begin
      tag = "R2"; return {1'b0, s, 63'd0};
    end
    if (e == 31 && !alt) begin
      if (f == 0) begin tag = "R4"; return {1'b0, s, 11'h7FF, 52'd0}; end
      tag = "R5/R7";
      return {~h[9], s, 11'h7FF, 1'b1, h[8:0], 42'd0};
    end
    if (e == 0) begin tag = "R3"; v = real'(f) * pow2(-24); end
    else begin
      tag = (e == 31) ? "R6" : "R1";
      v = real'(1024 + f) * pow2(e - 25);
    end
    if (s) v = -v;
    return {1'b0, $realtobits(v)};
  endfunction

  task automatic check(string req, logic [64:0] act, logic [64:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    logic [64:0] e_a, e_b, prev;
    string tg;
    logic have_prev;
    rst = 1'b1; alt_mode = 1'b0; in_valid = 1'b0; in_half = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {64'd0, out_valid}, 65'd0);
    check("R8 ready in reset", {64'd0, in_ready}, 65'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle after reset", {64'd0, out_valid}, 65'd0);

    // stall phase: alt-mode top binade word held under back-pressure
    e_a = model(16'hFC05, 1'b1, tg);
    e_b = model(16'h0001, 1'b0, tg);
    alt_mode = 1'b1; in_half = 16'hFC05; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R8 result after accept", {64'd0, out_valid}, 65'd1);
    check("R6 alt top binade", {out_invalid, out_double}, e_a);
    alt_mode = 1'b0; in_half = 16'h0001;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 ready low while held", {64'd0, in_ready}, 65'd0);
      check("R10 held result unchanged", {out_invalid, out_double}, e_a);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 next word after drain", {out_invalid, out_double}, e_b);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 empty after drain", {64'd0, out_valid}, 65'd0);

    // exhaustive sweep, both modes, one word per cycle
    have_prev = 1'b0;
    prev = '0;
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 65536; v++) begin
        if (have_prev) check(tg, {out_invalid, out_double}, prev);
        alt_mode = m[0]; in_half = v[15:0]; in_valid = 1'b1;
        prev = model(v[15:0], m[0], tg);
        have_prev = 1'b1;
        @(negedge clk);
      end
    end
    check(tg, {out_invalid, out_double}, prev);
    in_valid = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule